// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block is the digital control side of a pair of eight-input successive-approximation converters. Each of the two sequencer instances holds a control word made of a channel mask, a clock divider value, a repeat-scan enable and a 3-bit start code. From these it decides which input to convert next and when each conversion ends. The analog part is replaced by a sample port. While a conversion runs, the sequencer holds a request high together with the channel index. On the last converter-clock tick of the conversion it captures the 10-bit value presented to it.

Software can run the block in two ways. It can write start code 001 to launch one conversion on the lowest channel in the mask. It can also set the repeat-scan bit with a zero start code, and the sequencer then cycles through the masked channels from the lowest upward, with no idle cycle between conversions. A shared trigger input launches a single conversion on every idle instance that is in single-shot mode, all in the same clock cycle. Each result is posted to a data word that carries a done flag, the result and the channel it came from. Reading that word clears the done flag.

Top module: `adc_dual_seq`

## Requirements
- R1: After reset, each control word reads 0x00000001 and each data word reads 0x00000000. Control word fields: mask [7:0], divider [15:8], repeat-scan [16], start code [26:24].
- R2: Mask bit i selects channel i. When an idle instance receives a control write with repeat-scan 0 and start code 001, it converts the lowest selected channel once and then returns to idle.
- R3: A mask of zero behaves exactly like a mask of 0x01, so channel 0 is converted.
- R4: A conversion lasts 11 × (divider + 1) clock cycles, from the edge that launches it to the edge that posts its result. The divider value is taken at launch.
- R5: With repeat-scan 1 and start code 000, the instance converts the set mask bits in ascending order and wraps from the highest back to the lowest. Each new conversion begins on the edge that posts the previous one.
- R6: If repeat-scan is cleared during a conversion, that conversion still runs to the end and posts its result. The instance is idle on the posting edge.
- R7: With repeat-scan 1 and a non-zero start code, no conversion begins.
- R8: Data word layout: done flag [31], channel [26:24], result [15:6]. All other bits read 0. On the posting edge the result is set to the sample input value present in that cycle, and the done flag is set.
- R9: A read strobe clears the done flag on the next edge. If a result is posted on the same edge, the done flag stays set.
- R10: A pulse on the shared trigger launches a conversion on every idle instance with repeat-scan 0, and all of them start on the same edge.
- R11: A single-shot start request that arrives while a conversion is running is ignored. It starts no extra conversion.
- R12: The sample request is high for exactly the duration of each conversion. The requested channel stays constant until that conversion posts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gstart_i | input | 1 | Shared trigger for all instances |
| ctrl_we_i | input | N_CONV | Control word write strobe, one per instance |
| ctrl_wdata_i | input | N_CONV×32 | Control word write data |
| ctrl_o | output | N_CONV×32 | Control word readback |
| data_re_i | input | N_CONV | Data word read strobe |
| data_o | output | N_CONV×32 | Data word: done, channel, result |
| smp_req_o | output | N_CONV | Conversion in progress, sample requested |
| smp_chan_o | output | N_CONV×3 | Channel being converted |
| smp_data_i | input | N_CONV×10 | Converted value from the analog side |

## Verification
The bench builds the block with its default values: two instances, eight channels, 10-bit results and 11 ticks per conversion. Two instances are enough to check that the shared trigger starts both on the same edge, and to run a scan on one instance while the other sits idle. The bench uses divider values of 0, 1 and 3. These keep each conversion short enough for many wrap-arounds of a scan, and they still show that latency scales with the divider. A behavioural model that counts the remaining cycles runs beside the design, and the two are compared on every clock.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned SEL_W      = 8;
  localparam int unsigned DIV_W      = 8;
  localparam int unsigned START_W    = 3;
  localparam int unsigned RES_W      = 10;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned CONV_TICKS = 11;
  localparam int unsigned CH_W       = $clog2(SEL_W);

  localparam int unsigned SEL_LSB   = 0;
  localparam int unsigned DIV_LSB   = 8;
  localparam int unsigned BURST_BIT = 16;
  localparam int unsigned START_LSB = 24;
  localparam int unsigned DONE_BIT  = 31;
  localparam int unsigned RCH_LSB   = 24;
  localparam int unsigned RES_LSB   = 6;

  localparam logic [START_W-1:0] START_SW = START_W'(1);

  typedef enum logic {ST_IDLE, ST_CONV} seq_st_e;

  typedef struct packed {
    logic [START_W-1:0] start;
    logic               burst;
    logic [DIV_W-1:0]   div;
    logic [SEL_W-1:0]   sel;
  } ctrl_t;

  function automatic ctrl_t ctrl_unpack(input logic [REG_W-1:0] w);
    ctrl_t c;
    c.sel   = w[SEL_LSB +: SEL_W];
    c.div   = w[DIV_LSB +: DIV_W];
    c.burst = w[BURST_BIT];
    c.start = w[START_LSB +: START_W];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] ctrl_pack(input ctrl_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[SEL_LSB +: SEL_W]     = c.sel;
    w[DIV_LSB +: DIV_W]     = c.div;
    w[BURST_BIT]            = c.burst;
    w[START_LSB +: START_W] = c.start;
    return w;
  endfunction
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [DW-1:0] div_i,
  output logic          tick_o
);
  logic [DW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + DW'(1);
  end

  // ticks are spaced div+1 cycles apart
  p_tick_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i != '0 && !clr_i) |=> !tick_o)
    else $error("converter tick repeated with divider above zero");
endmodule

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
  parameter int unsigned CH_NUM = 8,
  localparam int unsigned CW = $clog2(CH_NUM)
) (
  input  logic [CH_NUM-1:0] mask_i,
  input  logic [CW-1:0]     cur_i,
  output logic [CW-1:0]     first_o,
  output logic [CW-1:0]     next_o
);
  logic [CH_NUM-1:0] eff;
  logic [CW-1:0]     idx;

  always_comb begin
    eff = (mask_i == '0) ? CH_NUM'(1) : mask_i;
    first_o = '0;
    for (int i = CH_NUM - 1; i >= 0; i--) begin
      if (eff[i]) first_o = CW'(i);
    end
    // nearest set bit above cur, wrapping; CH_NUM is a power of two
    next_o = cur_i;
    idx    = '0;
    for (int j = CH_NUM - 1; j >= 1; j--) begin
      idx = cur_i + CW'(j);
      if (eff[idx]) next_o = idx;
    end
  end
endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core
  import adc_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gstart_i,
  input  logic             ctrl_we_i,
  input  logic [REG_W-1:0] ctrl_wdata_i,
  output logic [REG_W-1:0] ctrl_o,
  input  logic             data_re_i,
  output logic [REG_W-1:0] data_o,
  output logic             smp_req_o,
  output logic [CH_W-1:0]  smp_chan_o,
  input  logic [RES_W-1:0] smp_data_i
);
  localparam int unsigned CNT_W = $clog2(CONV_TICKS);
  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(CONV_TICKS - 1);

  ctrl_t            ctrl_q, ctrl_w, ctrl_n;
  seq_st_e          st_q;
  logic [CH_W-1:0]  chan_q, chan_first, chan_next, rch_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] tcnt_q;
  logic [RES_W-1:0] res_q;
  logic             done_q;
  logic             tick, fin, run_burst, sw_go, launch, cont;

  always_comb begin
    ctrl_w    = ctrl_unpack(ctrl_wdata_i);
    ctrl_n    = ctrl_we_i ? ctrl_w : ctrl_q;
    run_burst = ctrl_n.burst && (ctrl_n.start == '0);
    sw_go     = (ctrl_we_i && ctrl_w.start == START_SW && !ctrl_w.burst) ||
                (gstart_i && !ctrl_n.burst);
    launch    = (st_q == ST_IDLE) && (run_burst || sw_go);
    fin       = (st_q == ST_CONV) && tick && (tcnt_q == LAST_TICK);
    cont      = fin && run_burst;
  end

  adc_chan_pick #(.CH_NUM(SEL_W)) u_pick (
    .mask_i (ctrl_n.sel),
    .cur_i  (chan_q),
    .first_o(chan_first),
    .next_o (chan_next)
  );

  adc_clk_div #(.DW(DIV_W)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (launch || cont),
    .en_i  (st_q == ST_CONV),
    .div_i (div_q),
    .tick_o(tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= ctrl_unpack(REG_W'(1));
    else if (ctrl_we_i) ctrl_q <= ctrl_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      chan_q <= '0;
      div_q  <= '0;
      tcnt_q <= '0;
    end else if (launch) begin
      st_q   <= ST_CONV;
      chan_q <= chan_first;
      div_q  <= ctrl_n.div;
      tcnt_q <= '0;
    end else if (fin) begin
      tcnt_q <= '0;
      if (cont) begin
        chan_q <= chan_next;
        div_q  <= ctrl_n.div;
      end else begin
        st_q <= ST_IDLE;
      end
    end else if (tick) begin
      tcnt_q <= tcnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      res_q  <= '0;
      rch_q  <= '0;
    end else if (fin) begin
      done_q <= 1'b1;
      res_q  <= smp_data_i;
      rch_q  <= chan_q;
    end else if (data_re_i) begin
      done_q <= 1'b0;
    end
  end

  always_comb begin
    data_o = '0;
    data_o[DONE_BIT]           = done_q;
    data_o[RCH_LSB +: CH_W]    = rch_q;
    data_o[RES_LSB +: RES_W]   = res_q;
  end

  assign ctrl_o     = ctrl_pack(ctrl_q);
  assign smp_req_o  = (st_q == ST_CONV);
  assign smp_chan_o = chan_q;

  p_chan_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CONV && !fin) |=> (st_q == ST_CONV) && $stable(chan_q))
    else $error("channel or request changed mid-conversion");

  p_post_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin |=> done_q && (rch_q == $past(chan_q)) && (res_q == $past(smp_data_i)))
    else $error("result not posted on final tick");

  p_rd_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_re_i && !fin) |=> !done_q)
    else $error("read did not clear done");

  p_blocked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && ctrl_q.burst && ctrl_q.start != '0 && !ctrl_we_i) |=> st_q == ST_IDLE)
    else $error("scan started with non-zero start code");

  p_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin && !ctrl_we_i && !ctrl_q.burst) |=> st_q == ST_IDLE)
    else $error("sequencer kept running after scan was cleared");

  p_tcnt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tcnt_q <= LAST_TICK)
    else $error("tick counter out of range");
endmodule

// File: rtl/adc_dual_seq.sv
module adc_dual_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned N_CONV = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         gstart_i,
  input  logic [N_CONV-1:0]            ctrl_we_i,
  input  logic [N_CONV-1:0][REG_W-1:0] ctrl_wdata_i,
  output logic [N_CONV-1:0][REG_W-1:0] ctrl_o,
  input  logic [N_CONV-1:0]            data_re_i,
  output logic [N_CONV-1:0][REG_W-1:0] data_o,
  output logic [N_CONV-1:0]            smp_req_o,
  output logic [N_CONV-1:0][CH_W-1:0]  smp_chan_o,
  input  logic [N_CONV-1:0][RES_W-1:0] smp_data_i
);
  for (genvar k = 0; k < N_CONV; k++) begin : g_conv
    adc_seq_core u_core (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .gstart_i    (gstart_i),
      .ctrl_we_i   (ctrl_we_i[k]),
      .ctrl_wdata_i(ctrl_wdata_i[k]),
      .ctrl_o      (ctrl_o[k]),
      .data_re_i   (data_re_i[k]),
      .data_o      (data_o[k]),
      .smp_req_o   (smp_req_o[k]),
      .smp_chan_o  (smp_chan_o[k]),
      .smp_data_i  (smp_data_i[k])
    );

    p_gstart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gstart_i && !smp_req_o[k] && !ctrl_o[k][BURST_BIT] && !ctrl_we_i[k]) |=> smp_req_o[k])
      else $error("shared trigger did not launch idle instance");
  end
endmodule

// File: tb/tb_adc_dual_seq.sv
`timescale 1ns/1ps
module tb_adc_dual_seq;
  localparam int NC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gstart = 1'b0;
  logic [NC-1:0] we = '0;
  logic [NC-1:0][31:0] wdata = '0;
  logic [NC-1:0] re = '0;
  logic [NC-1:0][31:0] ctrl_o, data_o;
  logic [NC-1:0] req;
  logic [NC-1:0][2:0] chan;
  logic [NC-1:0][9:0] smp;

  int n_cmp = 0;
  int n_bad = 0;
  bit ended = 0;

  always #4 clk = ~clk;

  adc_dual_seq #(.N_CONV(NC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .gstart_i(gstart),
    .ctrl_we_i(we), .ctrl_wdata_i(wdata), .ctrl_o(ctrl_o),
    .data_re_i(re), .data_o(data_o),
    .smp_req_o(req), .smp_chan_o(chan), .smp_data_i(smp)
  );

  function automatic logic [9:0] samp(input int k, input int ch);
    return 10'((k * 300 + ch * 37 + 5) % 1024);
  endfunction

  always_comb begin
    for (int k = 0; k < NC; k++) smp[k] = samp(k, int'(chan[k]));
  end

  // behavioural reference model
  int m_sel[NC], m_div[NC], m_burst[NC], m_start[NC];
  int m_busy[NC], m_chan[NC], m_rem[NC], m_done[NC], m_res[NC], m_rch[NC];

  function automatic int lowest(input int mask);
    int e = (mask == 0) ? 1 : mask;
    for (int i = 0; i < 8; i++) if (e[i]) return i;
    return 0;
  endfunction

  function automatic int next_up(input int mask, input int cur);
    int e = (mask == 0) ? 1 : mask;
    for (int j = 1; j <= 8; j++) if (e[(cur + j) % 8]) return (cur + j) % 8;
    return cur;
  endfunction

  always @(posedge clk) begin
    for (int k = 0; k < NC; k++) begin
      if (!rst_n) begin
        m_sel[k] = 1; m_div[k] = 0; m_burst[k] = 0; m_start[k] = 0;
        m_busy[k] = 0; m_chan[k] = 0; m_rem[k] = 0;
        m_done[k] = 0; m_res[k] = 0; m_rch[k] = 0;
      end else begin
        int ns, nd, nb, nst, ws, wb;
        bit run, sw, fin;
        ws  = int'(wdata[k][26:24]);
        wb  = int'(wdata[k][16]);
        ns  = we[k] ? int'(wdata[k][7:0])  : m_sel[k];
        nd  = we[k] ? int'(wdata[k][15:8]) : m_div[k];
        nb  = we[k] ? wb : m_burst[k];
        nst = we[k] ? ws : m_start[k];
        run = (nb != 0) && (nst == 0);
        sw  = (we[k] && ws == 1 && wb == 0) || (gstart && nb == 0);
        fin = (m_busy[k] != 0) && (m_rem[k] == 1);
        if (fin) begin
          m_done[k] = 1; m_res[k] = samp(k, m_chan[k]); m_rch[k] = m_chan[k];
        end else if (re[k]) m_done[k] = 0;
        if (m_busy[k] == 0) begin
          if (run || sw) begin
            m_busy[k] = 1; m_chan[k] = lowest(ns); m_rem[k] = 11 * (nd + 1);
          end
        end else if (fin) begin
          if (run) begin
            m_chan[k] = next_up(ns, m_chan[k]); m_rem[k] = 11 * (nd + 1);
          end else m_busy[k] = 0;
        end else m_rem[k] = m_rem[k] - 1;
        m_sel[k] = ns; m_div[k] = nd; m_burst[k] = nb; m_start[k] = nst;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !ended) begin
      for (int k = 0; k < NC; k++) begin
        logic [31:0] ed, ec;
        ed = '0;
        ed[31] = (m_done[k] != 0);
        ed[26:24] = 3'(m_rch[k]);
        ed[15:6] = 10'(m_res[k]);
        ec = '0;
        ec[7:0] = 8'(m_sel[k]);
        ec[15:8] = 8'(m_div[k]);
        ec[16] = (m_burst[k] != 0);
        ec[26:24] = 3'(m_start[k]);
        chk("R8 model data", data_o[k], ed);
        chk("R1 model ctrl", ctrl_o[k], ec);
        chk("R12 model req", 32'(req[k]), 32'(m_busy[k] != 0));
        if (m_busy[k] != 0) chk("R12 model chan", 32'(chan[k]), 32'(m_chan[k]));
      end
    end
  end

  task automatic wr(input int k, input int sel, input int dv, input int bu, input int st);
    @(negedge clk);
    we[k] = 1'b1;
    wdata[k] = '0;
    wdata[k][7:0] = 8'(sel);
    wdata[k][15:8] = 8'(dv);
    wdata[k][16] = bu[0];
    wdata[k][26:24] = 3'(st);
    @(negedge clk);
    we[k] = 1'b0;
  endtask

  task automatic rd(input int k);
    @(negedge clk);
    re[k] = 1'b1;
    @(negedge clk);
    re[k] = 1'b0;
  endtask

  task automatic wait_done(input int k, output int n);
    n = 1;
    while (!data_o[k][31] && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic summary();
    ended = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog act=running exp=finished");
    summary();
  end

  initial begin
    int n, idx, gaps, got[5], expv[5], hi;
    expv = '{0, 4, 7, 0, 4};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ctrl0 reset", ctrl_o[0], 32'h1);
    chk("R1 ctrl1 reset", ctrl_o[1], 32'h1);
    chk("R1 data0 reset", data_o[0], 32'h0);

    // single shot, mask 0x28, divider 1
    wr(0, 8'h28, 1, 0, 1);
    wait_done(0, n);
    chk("R4 latency div1", 32'(n), 32'(11 * 2 + 1));
    chk("R2 lowest channel", 32'(data_o[0][26:24]), 32'd3);
    chk("R8 result", 32'(data_o[0][15:6]), 32'(samp(0, 3)));
    chk("R2 back to idle", 32'(req[0]), 32'd0);

    rd(0);
    chk("R9 read clears done", 32'(data_o[0][31]), 32'd0);

    // empty mask
    wr(0, 0, 0, 0, 1);
    wait_done(0, n);
    chk("R3 zero mask channel", 32'(data_o[0][26:24]), 32'd0);
    chk("R4 latency div0", 32'(n), 32'd12);

    // start while busy is ignored
    rd(0);
    wr(0, 8'h40, 3, 0, 1);
    repeat (5) @(negedge clk);
    wr(0, 8'h02, 0, 0, 1);
    wait_done(0, n);
    chk("R11 original channel kept", 32'(data_o[0][26:24]), 32'd6);
    repeat (3) @(negedge clk);
    chk("R11 no relaunch", 32'(req[0]), 32'd0);

    // shared trigger
    rd(0);
    @(negedge clk);
    gstart = 1'b1;
    @(negedge clk);
    gstart = 1'b0;
    chk("R10 inst0 started", 32'(req[0]), 32'd1);
    chk("R10 inst1 started", 32'(req[1]), 32'd1);
    wait_done(0, n);
    chk("R10 same posting cycle", 32'(data_o[1][31]), 32'd1);
    chk("R10 inst0 channel", 32'(data_o[0][26:24]), 32'd1);

    // scan on instance 1, read strobe held high
    re[1] = 1'b1;
    wr(1, 8'h91, 0, 1, 0);
    idx = 0; gaps = 0; hi = 0;
    while (idx < 5 && hi < 500) begin
      if (!req[1]) gaps++;
      if (data_o[1][31]) begin
        got[idx] = int'(data_o[1][26:24]);
        idx++;
      end
      hi++;
      @(negedge clk);
    end
    for (int i = 0; i < 5; i++) chk("R5 scan order", 32'(got[i]), 32'(expv[i]));
    chk("R5 no idle gap", 32'(gaps), 32'd0);

    // clear scan mid-conversion
    repeat (2) @(negedge clk);
    wr(1, 8'h91, 0, 0, 0);
    gaps = 0; hi = 0;
    while (!data_o[1][31] && hi < 100) begin
      if (!req[1]) gaps++;
      hi++;
      @(negedge clk);
    end
    chk("R6 in-flight completes", 32'(data_o[1][26:24]), 32'd7);
    chk("R6 request held", 32'(gaps), 32'd0);
    chk("R6 idle after post", 32'(req[1]), 32'd0);
    re[1] = 1'b0;

    // blocked scan
    wr(1, 8'h91, 0, 1, 2);
    hi = 0;
    repeat (30) begin
      @(negedge clk);
      if (req[1]) hi++;
    end
    chk("R7 blocked scan", 32'(hi), 32'd0);
    wr(1, 8'h91, 0, 1, 0);
    chk("R7 unblocked scan", 32'(req[1]), 32'd1);
    wr(1, 8'h91, 0, 0, 0);
    repeat (20) @(negedge clk);
    chk("R6 stopped", 32'(req[1]), 32'd0);

    summary();
  end
endmodule